// File: doc/BRIEF.md
# Branch and Subroutine Sequencer

This block is the program-flow engine of a small byte-wide processor with a 16-bit address space. It fetches opcodes over a single byte-wide memory bus, owns the program counter and the stack pointer, and carries out unconditional jumps, the eight flag-conditional jumps, subroutine call, subroutine return, a stack-pointer load and a halt. Every other opcode is consumed as a one-byte no-operation. The flags come from elsewhere and are only read.

Each clock period is one T-state. Every instruction runs as a fixed sequence of machine cycles: an opcode fetch, then memory reads and memory writes, each of a fixed T-state length. A one-clock strobe marks the first T-state of every machine cycle. The read and write strobes are asserted in the second T-state only, and the bus address is held for the whole machine cycle. The memory returns read data combinationally from the address, and a write takes effect on the clock edge that ends the strobed T-state.

The flag input uses these bit positions: bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry.

Top module: `flow_sequencer`

## Requirements
- R1: While reset is held low and after its release, the program counter and stack pointer read 0000h and the halt output is low. The first machine cycle after release is an opcode fetch from address 0000h.
- R2: Every machine cycle starts with a one-clock `cycle_start` pulse in its first T-state. `mem_rd` or `mem_wr` is high only in the second T-state, never both at once. `mem_addr` does not change within a machine cycle.
- R3: An opcode fetch lasts 6 T-states for opcode CDh and 4 T-states for every other opcode. Each memory read or write cycle lasts 3 T-states.
- R4: Opcode C3h reads the target low byte and then the high byte from the next two addresses and continues at the target, for 10 T-states in total.
- R5: An opcode of the form 11ccc010 is a conditional jump. Bits 5:4 select the flag (00 zero, 01 carry, 10 parity, 11 sign), and bit 3 is the value that makes the jump taken. A taken jump continues at the target. An untaken jump continues at its own address plus 3. Both cost 10 T-states.
- R6: The auxiliary carry flag (bit 2) has no effect on any instruction.
- R7: Opcode CDh reads the target, then writes the return address (the call's address plus 3) with the high byte to SP-1 and then the low byte to SP-2. It leaves SP lowered by 2 and continues at the target, for 18 T-states in total.
- R8: Opcode C9h reads the low byte from SP and the high byte from SP+1, raises SP by 2 and continues at the address read, for 10 T-states in total.
- R9: Stack addresses and stack-pointer updates wrap modulo 65536: a call with SP = 0000h writes to FFFFh and FFFEh.
- R10: Opcode 31h loads SP from the next two bytes, low byte first, for 10 T-states in total, and continues after its 3 bytes.
- R11: Opcode 76h completes its 4-T-state fetch and then raises `halted`. From then on until reset, `halted` stays high and the block issues no further strobes.
- R12: Any opcode not listed above costs one 4-T-state fetch, advances the program counter by 1 and does nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | 8 | Read data returned for `mem_addr` |
| flags | input | 5 | Sign, zero, auxiliary carry, parity, carry (bits 4..0) |
| mem_addr | output | 16 | Bus address, held for a whole machine cycle |
| mem_wdata | output | 8 | Write data, valid while `mem_wr` is high |
| mem_rd | output | 1 | Read strobe, second T-state of read cycles |
| mem_wr | output | 1 | Write strobe, second T-state of write cycles |
| cycle_start | output | 1 | High in the first T-state of every machine cycle |
| halted | output | 1 | High after a halt opcode until reset |
| prog_ctr | output | 16 | Current program counter |
| stack_ptr | output | 16 | Current stack pointer |

## Verification
Two events share one clock edge. At the end of a call's last write cycle, the final stack-pointer decrement and the load of the target into the program counter happen together. At the end of a return, the final stack-pointer increment and the load of the popped address happen together. The bench provokes both with nested calls and returns, one set with the stack at 5000h and one with it starting at 0000h so that both updates wrap. A behavioural model predicts, for every T-state, the strobes, the address, the write data and the stack pointer at each fetch. Any mismatch in either register, or any misplaced stack byte, is reported against the requirement concerned.

// File: rtl/flow_pkg.sv
// Shared constants and types for the branch and subroutine sequencer.
// Assumes a byte-wide bus and a two-byte address, both fixed by the
// instruction encoding.
package flow_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int FLAG_W = 5;

    // Flag bit positions on the flag input.
    localparam int FLAG_CARRY  = 0;
    localparam int FLAG_PARITY = 1;
    localparam int FLAG_AUX    = 2;
    localparam int FLAG_ZERO   = 3;
    localparam int FLAG_SIGN   = 4;

    localparam logic [BYTE_W-1:0] OPC_JMP   = 8'hC3;
    localparam logic [BYTE_W-1:0] OPC_CALL  = 8'hCD;
    localparam logic [BYTE_W-1:0] OPC_RET   = 8'hC9;
    localparam logic [BYTE_W-1:0] OPC_LDSP  = 8'h31;
    localparam logic [BYTE_W-1:0] OPC_HALT  = 8'h76;
    localparam logic [BYTE_W-1:0] JCC_MASK  = 8'hC7;
    localparam logic [BYTE_W-1:0] JCC_MATCH = 8'hC2;

    typedef enum logic [2:0] {
        KIND_NOP, KIND_JMP, KIND_JCC, KIND_CALL, KIND_RET, KIND_LDSP, KIND_HALT
    } kind_e;

    typedef enum logic [2:0] {
        MC_FETCH, MC_RD_LO, MC_RD_HI, MC_WR_HI, MC_WR_LO, MC_HALT
    } mcyc_e;
endpackage

// File: rtl/flow_decode.sv
// Opcode classifier: names the instruction kind, evaluates the jump
// condition straight from opcode bits and gives the fetch length.
// Assumes the opcode register is stable from the third fetch T-state on.
module flow_decode
    import flow_pkg::*;
#(
    parameter int TW          = 3,
    parameter int FETCH_SHORT = 4,
    parameter int FETCH_LONG  = 6
) (
    input  logic [BYTE_W-1:0] opcode,
    input  logic [FLAG_W-1:0] flags,
    output kind_e             kind,
    output logic              cond_ok,
    output logic [TW-1:0]     fetch_len
);
    logic flag_sel;
    logic unused_aux;

    assign unused_aux = flags[FLAG_AUX];

    // Classify the opcode into one of the handled instruction kinds.
    always_comb begin
        if (opcode == OPC_JMP)                        kind = KIND_JMP;
        else if ((opcode & JCC_MASK) == JCC_MATCH)    kind = KIND_JCC;
        else if (opcode == OPC_CALL)                  kind = KIND_CALL;
        else if (opcode == OPC_RET)                   kind = KIND_RET;
        else if (opcode == OPC_LDSP)                  kind = KIND_LDSP;
        else if (opcode == OPC_HALT)                  kind = KIND_HALT;
        else                                          kind = KIND_NOP;
    end

    // Pick the flag tested by a conditional jump from opcode bits 5:4.
    always_comb begin
        case (opcode[5:4])
            2'b00:   flag_sel = flags[FLAG_ZERO];
            2'b01:   flag_sel = flags[FLAG_CARRY];
            2'b10:   flag_sel = flags[FLAG_PARITY];
            default: flag_sel = flags[FLAG_SIGN];
        endcase
    end

    assign cond_ok   = (flag_sel == opcode[3]);
    assign fetch_len = (opcode == OPC_CALL) ? TW'(FETCH_LONG) : TW'(FETCH_SHORT);
endmodule

// File: rtl/flow_tcount.sv
// T-state counter: counts 1..len within a machine cycle and flags the
// first and last T-state. Assumes len >= 3 and holds while hold is high.
module flow_tcount #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [TW-1:0] len,
    output logic [TW-1:0] t_now,
    output logic          t_first,
    output logic          t_last
);
    logic [TW-1:0] t_q;

    // Advance the T-state, wrapping to 1 after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)        t_q <= TW'(1);
        else if (!hold)    t_q <= t_last ? TW'(1) : t_q + TW'(1);
    end

    assign t_now   = t_q;
    assign t_first = (t_q == TW'(1));
    assign t_last  = (t_q == len);
endmodule

// File: rtl/flow_regs.sv
// Program counter and stack pointer. A load wins over a step; the
// sequencer never asks for two steps of one register in one cycle.
module flow_regs
    import flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_inc,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic              sp_inc,
    input  logic              sp_dec,
    input  logic              sp_load,
    input  logic [ADDR_W-1:0] sp_next,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] sp_q
);
    // Update the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (pc_load)  pc_q <= pc_next;
        else if (pc_inc)   pc_q <= pc_q + ADDR_W'(1);
    end

    // Update the stack pointer; arithmetic wraps at the address width.
    always_ff @(posedge clk) begin
        if (!rst_n)        sp_q <= '0;
        else if (sp_load)  sp_q <= sp_next;
        else if (sp_inc)   sp_q <= sp_q + ADDR_W'(1);
        else if (sp_dec)   sp_q <= sp_q - ADDR_W'(1);
    end
endmodule

// File: rtl/flow_sequencer.sv
// Branch and subroutine sequencer top. It walks each instruction through
// its machine cycles one T-state per clock, drives the byte bus and steers
// the PC/SP updates. Assumes combinational read data from the memory and
// a write that lands on the edge ending the strobed T-state.
module flow_sequencer
    import flow_pkg::*;
#(
    parameter int FETCH_SHORT = 4,
    parameter int FETCH_LONG  = 6,
    parameter int MEM_T       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [FLAG_W-1:0] flags,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              cycle_start,
    output logic              halted,
    output logic [ADDR_W-1:0] prog_ctr,
    output logic [ADDR_W-1:0] stack_ptr
);
    localparam int TW       = $clog2(FETCH_LONG + 1);
    localparam int STROBE_T = 2;

    mcyc_e             mc_q;
    logic [BYTE_W-1:0] opcode_q, lo_q, hi_q;
    kind_e             kind;
    logic              cond_ok;
    logic [TW-1:0]     fetch_len, cyc_len, t_now;
    logic              t_first, t_last, strobe_t;
    logic              read_mc, write_mc, operand_mc, use_sp_rd;
    logic              pc_inc, pc_load, sp_inc, sp_dec, sp_load;
    logic [ADDR_W-1:0] pc_q, sp_q, jump_tgt;

    flow_decode #(
        .TW(TW), .FETCH_SHORT(FETCH_SHORT), .FETCH_LONG(FETCH_LONG)
    ) u_decode (
        .opcode(opcode_q), .flags(flags),
        .kind(kind), .cond_ok(cond_ok), .fetch_len(fetch_len)
    );

    flow_tcount #(.TW(TW)) u_tcount (
        .clk(clk), .rst_n(rst_n), .hold(mc_q == MC_HALT), .len(cyc_len),
        .t_now(t_now), .t_first(t_first), .t_last(t_last)
    );

    flow_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .pc_inc(pc_inc), .pc_load(pc_load), .pc_next(jump_tgt),
        .sp_inc(sp_inc), .sp_dec(sp_dec), .sp_load(sp_load), .sp_next(jump_tgt),
        .pc_q(pc_q), .sp_q(sp_q)
    );

    assign jump_tgt   = {hi_q, lo_q};
    assign cyc_len    = (mc_q == MC_FETCH) ? fetch_len : TW'(MEM_T);
    assign strobe_t   = (t_now == TW'(STROBE_T));
    assign operand_mc = (mc_q == MC_RD_LO) || (mc_q == MC_RD_HI);
    assign read_mc    = (mc_q == MC_FETCH) || operand_mc;
    assign write_mc   = (mc_q == MC_WR_HI) || (mc_q == MC_WR_LO);
    assign use_sp_rd  = operand_mc && (kind == KIND_RET);

    // Bus outputs: address source, write byte and strobes.
    always_comb begin
        if (write_mc)        mem_addr = sp_q - ADDR_W'(1);
        else if (use_sp_rd)  mem_addr = sp_q;
        else                 mem_addr = pc_q;
        mem_wdata   = (mc_q == MC_WR_HI) ? pc_q[ADDR_W-1:BYTE_W] : pc_q[BYTE_W-1:0];
        mem_rd      = read_mc && strobe_t;
        mem_wr      = write_mc && strobe_t;
        cycle_start = t_first && (mc_q != MC_HALT);
        halted      = (mc_q == MC_HALT);
    end

    // Register steering at the last T-state of a machine cycle.
    always_comb begin
        pc_inc  = t_last && read_mc && !use_sp_rd;
        pc_load = t_last && (((mc_q == MC_RD_HI) &&
                              ((kind == KIND_JMP) || (kind == KIND_RET) ||
                               ((kind == KIND_JCC) && cond_ok))) ||
                             (mc_q == MC_WR_LO));
        sp_inc  = t_last && use_sp_rd;
        sp_dec  = t_last && write_mc;
        sp_load = t_last && (mc_q == MC_RD_HI) && (kind == KIND_LDSP);
    end

    // Capture the opcode and operand bytes on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else if (mem_rd) begin
            case (mc_q)
                MC_FETCH: opcode_q <= mem_rdata;
                MC_RD_LO: lo_q     <= mem_rdata;
                MC_RD_HI: hi_q     <= mem_rdata;
                default:  ;
            endcase
        end
    end

    // Machine-cycle sequence per instruction kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q <= MC_FETCH;
        end else if (t_last) begin
            case (mc_q)
                MC_FETCH: begin
                    if (kind == KIND_HALT)      mc_q <= MC_HALT;
                    else if (kind == KIND_NOP)  mc_q <= MC_FETCH;
                    else                        mc_q <= MC_RD_LO;
                end
                MC_RD_LO: mc_q <= MC_RD_HI;
                MC_RD_HI: mc_q <= (kind == KIND_CALL) ? MC_WR_HI : MC_FETCH;
                MC_WR_HI: mc_q <= MC_WR_LO;
                MC_WR_LO: mc_q <= MC_FETCH;
                default:  mc_q <= mc_q;
            endcase
        end
    end

    assign prog_ctr  = pc_q;
    assign stack_ptr = sp_q;
endmodule

// File: rtl/flow_sequencer_chk.sv
// Port-level checker for the sequencer: bus strobe discipline, address
// hold within a machine cycle and the halt behaviour.
module flow_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        cycle_start,
    input logic        halted,
    input logic [15:0] mem_addr
);
    // R2: a read strobe and a write strobe never coincide.
    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: the machine-cycle marker lasts one clock.
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    // R2: a read strobe lasts one clock.
    assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R2: strobes never fall in the first T-state.
    assert_strobe_not_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !cycle_start);

    // R2: the address holds within a machine cycle.
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && !halted) |-> $stable(mem_addr));

    // R11: halt is sticky until reset.
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11: a halted block issues no strobes.
    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !cycle_start));
endmodule

bind flow_sequencer flow_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cycle_start(cycle_start), .halted(halted), .mem_addr(mem_addr)
);

// File: tb/tb_flow_sequencer.sv
`timescale 1ns/1ps
module tb_flow_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_rdata;
    logic [4:0]  flags;
    logic [15:0] mem_addr, prog_ctr, stack_ptr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, cycle_start, halted;

    int total = 0;
    int bad   = 0;
    bit fs, fz, fa, fp, fc;

    logic [7:0] dmem [256];
    logic [7:0] rmem [256];

    typedef struct {
        bit          st, rd, wr, hlt, chk;
        logic [15:0] addr, sp;
        logic [7:0]  wd;
        string       req;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    assign flags = {fs, fz, fa, fp, fc};

    flow_sequencer dut (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .flags(flags),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .cycle_start(cycle_start), .halted(halted),
        .prog_ctr(prog_ctr), .stack_ptr(stack_ptr)
    );

    // Bench memory: 256 bytes, folded on the low address byte.
    always_comb mem_rdata = dmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) dmem[mem_addr[7:0]] <= mem_wdata;

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit st, input bit rd, input bit wr, input bit hlt,
                        input bit chk, input logic [15:0] addr, input logic [15:0] sp,
                        input logic [7:0] wd, input string req);
        exp_t e;
        e.st = st; e.rd = rd; e.wr = wr; e.hlt = hlt; e.chk = chk;
        e.addr = addr; e.sp = sp; e.wd = wd; e.req = req;
        expq.push_back(e);
    endtask

    task automatic put(input int a, input logic [7:0] v);
        dmem[a] = v;
        rmem[a] = v;
    endtask

    task automatic rd_cyc(input logic [15:0] a, input string req);
        for (int t = 1; t <= 3; t++) push(t == 1, t == 2, 0, 0, 0, a, 16'h0, 8'h0, req);
    endtask

    task automatic wr_cyc(input logic [15:0] a, input logic [7:0] v, input string req);
        for (int t = 1; t <= 3; t++) push(t == 1, 0, t == 2, 0, 0, a, 16'h0, v, req);
        rmem[a[7:0]] = v;
    endtask

    // Behavioural reference: interprets the program and lists every T-state.
    task automatic model_run(input string jtag, input string ctag, input string rtag);
        logic [15:0] pc, sp, ra;
        logic [7:0]  op, lo, hi;
        bit          take, done;
        int          nf;
        string       ft;
        pc = 16'h0; sp = 16'h0; done = 0;
        for (int step = 0; step < 200 && !done; step++) begin
            op = rmem[pc[7:0]];
            nf = (op == 8'hCD) ? 6 : 4;
            ft = (op == 8'h76) ? "R11" :
                 (op == 8'hC3 || op == 8'hCD || op == 8'hC9 || op == 8'h31 ||
                  (op[7:6] == 2'b11 && op[2:0] == 3'b010)) ? "R3" : "R12";
            for (int t = 1; t <= nf; t++) push(t == 1, t == 2, 0, 0, t == 1, pc, sp, 8'h0, ft);
            pc = pc + 16'h1;
            case (op)
                8'hC3, 8'hC2, 8'hCA, 8'hD2, 8'hDA, 8'hE2, 8'hEA, 8'hF2, 8'hFA,
                8'hCD, 8'h31: begin
                    ft = (op == 8'hC3) ? "R4" : (op == 8'hCD) ? ctag : (op == 8'h31) ? "R10" : jtag;
                    rd_cyc(pc, ft); lo = rmem[pc[7:0]]; pc = pc + 16'h1;
                    rd_cyc(pc, ft); hi = rmem[pc[7:0]]; pc = pc + 16'h1;
                    case (op)
                        8'hC2: take = !fz;  8'hCA: take = fz;
                        8'hD2: take = !fc;  8'hDA: take = fc;
                        8'hE2: take = !fp;  8'hEA: take = fp;
                        8'hF2: take = !fs;  8'hFA: take = fs;
                        default: take = 1;
                    endcase
                    if (op == 8'h31) sp = {hi, lo};
                    else if (op == 8'hCD) begin
                        ra = pc;
                        wr_cyc(sp - 16'h1, ra[15:8], ctag); sp = sp - 16'h1;
                        wr_cyc(sp - 16'h1, ra[7:0], ctag);  sp = sp - 16'h1;
                        pc = {hi, lo};
                    end else if (take) pc = {hi, lo};
                end
                8'hC9: begin
                    rd_cyc(sp, rtag); lo = rmem[sp[7:0]]; sp = sp + 16'h1;
                    rd_cyc(sp, rtag); hi = rmem[sp[7:0]]; sp = sp + 16'h1;
                    pc = {hi, lo};
                end
                8'h76: begin
                    for (int k = 0; k < 6; k++) push(0, 0, 0, 1, 0, 16'h0, 16'h0, 8'h0, "R11");
                    done = 1;
                end
                default: ;
            endcase
        end
    endtask

    task automatic compare(input exp_t e);
        check(16'(cycle_start), 16'(e.st), "R2", "cycle_start");
        check(16'(mem_rd), 16'(e.rd), "R2", "mem_rd");
        check(16'(mem_wr), 16'(e.wr), "R2", "mem_wr");
        check(16'(halted), 16'(e.hlt), "R11", "halted");
        if (!e.hlt) check(mem_addr, e.addr, e.req, "mem_addr");
        if (e.wr)   check(16'(mem_wdata), 16'(e.wd), e.req, "mem_wdata");
        if (e.chk) begin
            check(prog_ctr, e.addr, e.req, "prog_ctr at fetch");
            check(stack_ptr, e.sp, e.req, "stack_ptr at fetch");
        end
    endtask

    task automatic load_main();
        int a;
        put(8'h00, 8'h31); put(8'h01, 8'h00); put(8'h02, 8'h50);
        put(8'h03, 8'hC3); put(8'h04, 8'h08); put(8'h05, 8'h00);
        put(8'h06, 8'h76); put(8'h07, 8'h76);
        for (int i = 0; i < 8; i++) begin
            a = 8 + 4 * i;
            put(a, {2'b11, 3'(i), 3'b010});
            put(a + 1, 8'(a + 4)); put(a + 2, 8'h00); put(a + 3, 8'h00);
        end
        put(8'h28, 8'hCD); put(8'h29, 8'h40); put(8'h2A, 8'h00);
        put(8'h2B, 8'h80); put(8'h2C, 8'h76);
        put(8'h40, 8'h00); put(8'h41, 8'hCD); put(8'h42, 8'h50); put(8'h43, 8'h00);
        put(8'h44, 8'hC9); put(8'h50, 8'hC9);
    endtask

    task automatic load_wrap();
        put(8'h00, 8'h00); put(8'h01, 8'hCD); put(8'h02, 8'h20); put(8'h03, 8'h00);
        put(8'h04, 8'h76);
        put(8'h20, 8'hCD); put(8'h21, 8'h30); put(8'h22, 8'h00); put(8'h23, 8'hC9);
        put(8'h30, 8'hC9);
    endtask

    task automatic run_prog(input int which, input string jtag, input string ctag,
                            input string rtag);
        int diffs;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) put(i, 8'h00);
        if (which == 0) load_main(); else load_wrap();
        expq.delete();
        model_run(jtag, ctag, rtag);
        repeat (3) @(negedge clk);
        check(prog_ctr, 16'h0, "R1", "reset prog_ctr");
        check(stack_ptr, 16'h0, "R1", "reset stack_ptr");
        check(16'(halted), 16'h0, "R1", "reset halted");
        check(16'(mem_rd | mem_wr), 16'h0, "R1", "reset strobes");
        rst_n = 1'b1;
        foreach (expq[i]) begin
            if (i > 0) @(negedge clk);
            compare(expq[i]);
        end
        diffs = 0;
        for (int i = 0; i < 256; i++) if (dmem[i] !== rmem[i]) diffs++;
        check(16'(diffs), 16'h0, ctag, "stack bytes in memory");
    endtask

    initial begin
        // Flags: zero and parity set, carry and sign clear.
        fs = 0; fz = 1; fa = 0; fp = 1; fc = 0;
        run_prog(0, "R5", "R7", "R8");
        // Opposite flags flip every conditional jump.
        fs = 1; fz = 0; fa = 0; fp = 0; fc = 1;
        run_prog(0, "R5", "R7", "R8");
        // R6: only auxiliary carry differs from the first run.
        fs = 0; fz = 1; fa = 1; fp = 1; fc = 0;
        run_prog(0, "R6", "R7", "R8");
        // R9: stack starts at 0000h, nested call and return wrap.
        fs = 1; fz = 1; fa = 1; fp = 1; fc = 1;
        run_prog(1, "R5", "R9", "R9");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule